// File: doc/BRIEF.md
# PCI Configuration Port Decoder

This block sits between a host I/O port bus and a downstream configuration request channel. It holds a 32-bit configuration address register, programmed through a dword write to port 0xCF8. It also serves a four-byte data window at ports 0xCFC to 0xCFF. When the address register's enable bit is set, a data-window access is turned into a configuration request whose register offset comes from the stored address and the port lane. The bus, device and function fields of the stored address must also equal a target that is fixed on static configuration inputs.

All other accesses complete locally. These are accesses while the window is disabled, accesses to any other device, illegal size and port pairs, and accesses to unrelated ports. Locally completed reads return zero and locally completed writes change nothing. Forwarded requests use a valid/ready handshake. A forwarded write completes when its request is accepted. A forwarded read completes when the response arrives, with the returned data zero-extended to the access size.

The host raises `io_req` and holds the request fields stable until `io_done` pulses for one cycle. Read data is valid on `io_rdata` during that cycle.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the address register is 0. A dword read of port 0xCF8 returns 0 and no downstream request is issued.
- R2: A dword write (size code 2) to port 0xCF8 stores the written value ANDed with 0x80FFFFFC. A later dword read of 0xCF8 returns the stored value.
- R3: A byte (size code 0) or word (size code 1) write to port 0xCF8 leaves the address register unchanged. A byte or word read of 0xCF8 returns 0.
- R4: While bit 31 of the address register is 0, writes to ports 0xCFC to 0xCFF issue no downstream request, and reads of those ports return 0.
- R5: Byte and word accesses at any of ports 0xCFC to 0xCFF are forwarded when enabled and matching. Each is sent with the offset (address bits 7:0 plus the port minus 0xCFC, modulo 256) and the host size code.
- R6: A dword access to the data window is forwarded only at port 0xCFC. At ports 0xCFD to 0xCFF a dword read returns 0 and a dword write issues no request.
- R7: Function is address bits 10:8, device is bits 15:11 and bus is bits 23:16. A request is forwarded only if all three equal `tgt_fn`, `tgt_dev` and `tgt_bus`. Otherwise a read returns 0 and a write issues no request.
- R8: A forwarded read completes only after `ds_rsp_valid`. It returns `ds_rsp_data` masked to 8 bits for a byte, 16 bits for a word and 32 bits for a dword.
- R9: `ds_req_valid` and its request fields stay stable until `ds_req_ready` is seen. A forwarded write completes after acceptance without waiting for a response.
- R10: Accesses to ports outside 0xCF8 and 0xCFC to 0xCFF, and accesses with the reserved size code 3, issue no request. Reads of this kind return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_bus | input | 8 | Static target bus number |
| tgt_dev | input | 5 | Static target device number |
| tgt_fn | input | 3 | Static target function number |
| io_req | input | 1 | Host access request, held until io_done |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | Host I/O port number |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_wdata | input | 32 | Host write data, right-justified |
| io_done | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Read data, valid with io_done |
| ds_req_valid | output | 1 | Downstream request valid |
| ds_req_ready | input | 1 | Downstream request accepted |
| ds_wr | output | 1 | Downstream request is a write |
| ds_offset | output | 8 | Configuration register offset |
| ds_size | output | 2 | Access size code |
| ds_wdata | output | 32 | Downstream write data |
| ds_rsp_valid | input | 1 | Read response valid |
| ds_rsp_data | input | 32 | Read response data, right-justified |

## Verification
The address register is exercised in three ways. An all-ones store shows the mask. Stores with non-zero low bits show that dword alignment is forced. Byte and word probes of 0xCF8 separate narrow accesses from real register traffic. Data-window traffic covers every lane at byte and word size, dword at the aligned and unaligned lanes, an offset that wraps at 0xFF, and stored addresses that differ from the target in only the bus, only the device or only the function field, so each field compare is shown to matter on its own. Response data with all bits set in the upper bytes checks the zero-extension. The downstream model varies its ready stall and its response latency, which checks that requests stay stable and that reads wait for the response.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int DATA_W  = 32;
  localparam int PORT_W  = 16;
  localparam int OFS_W   = 8;
  localparam int FN_W    = 3;
  localparam int DEV_W   = 5;
  localparam int BUS_W   = 8;
  localparam int FN_LSB  = OFS_W;
  localparam int DEV_LSB = FN_LSB + FN_W;
  localparam int BUS_LSB = DEV_LSB + DEV_W;
  localparam int EN_BIT  = DATA_W - 1;
  localparam int BDF_W   = BUS_W + DEV_W + FN_W;

  localparam logic [DATA_W-1:0] ADDR_KEEP =
    (DATA_W'(1) << EN_BIT) |
    (((DATA_W'(1) << (BUS_LSB + BUS_W)) - DATA_W'(1)) & ~DATA_W'(3));

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_ADDR_WR = 2'd1,
    ACC_ADDR_RD = 2'd2,
    ACC_FWD     = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_ACK   = 2'd3
  } state_e;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = DATA_W'(8'hFF);
      SZ_WORD: size_mask = DATA_W'(16'hFFFF);
      default: size_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/cfgdec_rst_sync.sv
module cfgdec_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/cfgdec_addr_reg.sv
module cfgdec_addr_reg
  import cfgdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] addr_q
);
  logic [DATA_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (wr_en) addr_d = wdata & ADDR_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/cfgdec_classify.sv
module cfgdec_classify
  import cfgdec_pkg::*;
#(
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [PORT_W-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic              en_bit,
  input  logic [BDF_W-1:0]  addr_bdf,
  input  logic [OFS_W-1:0]  addr_ofs,
  input  logic [BDF_W-1:0]  tgt_bdf,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [1:0]        io_size,
  output acc_e              kind,
  output logic [OFS_W-1:0]  ofs
);
  localparam int LANE_W = 2;

  logic [LANE_W-1:0] lane;
  logic              is_addr, in_win, bdf_hit, size_ok;

  always_comb begin
    lane    = io_port[LANE_W-1:0];
    is_addr = (io_port == ADDR_PORT);
    in_win  = (io_port[PORT_W-1:LANE_W] == DATA_PORT[PORT_W-1:LANE_W]);
    bdf_hit = (addr_bdf == tgt_bdf);
    size_ok = (io_size == SZ_BYTE) || (io_size == SZ_WORD) ||
              ((io_size == SZ_DWORD) && (lane == '0));
    ofs     = addr_ofs + OFS_W'(lane);

    kind = ACC_NONE;
    if (is_addr && (io_size == SZ_DWORD))
      kind = io_wr ? ACC_ADDR_WR : ACC_ADDR_RD;
    else if (in_win && en_bit && bdf_hit && size_ok)
      kind = ACC_FWD;
  end
endmodule

// File: rtl/cfgdec_seq.sv
module cfgdec_seq
  import cfgdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req,
  input  logic              io_wr,
  input  logic [1:0]        io_size,
  input  logic [DATA_W-1:0] io_wdata,
  input  acc_e              kind,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] addr_q,
  output logic              addr_wr_en,
  output logic              io_done,
  output logic [DATA_W-1:0] io_rdata,
  output logic              ds_req_valid,
  input  logic              ds_req_ready,
  output logic              ds_wr,
  output logic [OFS_W-1:0]  ds_offset,
  output logic [1:0]        ds_size,
  output logic [DATA_W-1:0] ds_wdata,
  input  logic              ds_rsp_valid,
  input  logic [DATA_W-1:0] ds_rsp_data
);
  state_e            st_q, st_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              wr_q, wr_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic [1:0]        sz_q, sz_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              cap_en;

  always_comb begin
    st_d       = st_q;
    rd_d       = rd_q;
    addr_wr_en = 1'b0;
    cap_en     = 1'b0;
    case (st_q)
      ST_IDLE: if (io_req) begin
        case (kind)
          ACC_ADDR_WR: begin addr_wr_en = 1'b1; rd_d = '0;     st_d = ST_ACK; end
          ACC_ADDR_RD: begin                    rd_d = addr_q; st_d = ST_ACK; end
          ACC_FWD:     begin cap_en = 1'b1;                    st_d = ST_ISSUE; end
          default:     begin                    rd_d = '0;     st_d = ST_ACK; end
        endcase
      end
      ST_ISSUE: if (ds_req_ready) begin
        if (wr_q) begin rd_d = '0; st_d = ST_ACK; end
        else            st_d = ST_WAIT;
      end
      ST_WAIT: if (ds_rsp_valid) begin
        rd_d = ds_rsp_data & size_mask(sz_q);
        st_d = ST_ACK;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wr_d  = wr_q;
    ofs_d = ofs_q;
    sz_d  = sz_q;
    wd_d  = wd_q;
    if (cap_en) begin
      wr_d  = io_wr;
      ofs_d = ofs;
      sz_d  = io_size;
      wd_d  = io_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rd_q  <= '0;
      wr_q  <= 1'b0;
      ofs_q <= '0;
      sz_q  <= SZ_BYTE;
      wd_q  <= '0;
    end else begin
      st_q  <= st_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      ofs_q <= ofs_d;
      sz_q  <= sz_d;
      wd_q  <= wd_d;
    end
  end

  assign io_done      = (st_q == ST_ACK);
  assign io_rdata     = rd_q;
  assign ds_req_valid = (st_q == ST_ISSUE);
  assign ds_wr        = wr_q;
  assign ds_offset    = ofs_q;
  assign ds_size      = sz_q;
  assign ds_wdata     = wd_q;
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfgdec_pkg::*;
#(
  parameter logic [PORT_W-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [PORT_W-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  tgt_bus,
  input  logic [DEV_W-1:0]  tgt_dev,
  input  logic [FN_W-1:0]   tgt_fn,
  input  logic              io_req,
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  input  logic [1:0]        io_size,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              io_done,
  output logic [DATA_W-1:0] io_rdata,
  output logic              ds_req_valid,
  input  logic              ds_req_ready,
  output logic              ds_wr,
  output logic [OFS_W-1:0]  ds_offset,
  output logic [1:0]        ds_size,
  output logic [DATA_W-1:0] ds_wdata,
  input  logic              ds_rsp_valid,
  input  logic [DATA_W-1:0] ds_rsp_data
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] addr_q;
  logic              addr_wr_en;
  acc_e              kind;
  logic [OFS_W-1:0]  ofs;

  cfgdec_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  cfgdec_addr_reg u_addr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (addr_wr_en),
    .wdata  (io_wdata),
    .addr_q (addr_q)
  );

  cfgdec_classify #(.ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_cls (
    .en_bit   (addr_q[EN_BIT]),
    .addr_bdf (addr_q[BUS_LSB+BUS_W-1:FN_LSB]),
    .addr_ofs (addr_q[OFS_W-1:0]),
    .tgt_bdf  ({tgt_bus, tgt_dev, tgt_fn}),
    .io_wr    (io_wr),
    .io_port  (io_port),
    .io_size  (io_size),
    .kind     (kind),
    .ofs      (ofs)
  );

  cfgdec_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .io_req       (io_req),
    .io_wr        (io_wr),
    .io_size      (io_size),
    .io_wdata     (io_wdata),
    .kind         (kind),
    .ofs          (ofs),
    .addr_q       (addr_q),
    .addr_wr_en   (addr_wr_en),
    .io_done      (io_done),
    .io_rdata     (io_rdata),
    .ds_req_valid (ds_req_valid),
    .ds_req_ready (ds_req_ready),
    .ds_wr        (ds_wr),
    .ds_offset    (ds_offset),
    .ds_size      (ds_size),
    .ds_wdata     (ds_wdata),
    .ds_rsp_valid (ds_rsp_valid),
    .ds_rsp_data  (ds_rsp_data)
  );
endmodule

// File: rtl/cfgdec_checker.sv
module cfgdec_checker
  import cfgdec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_W-1:0]  tgt_bus,
  input logic [DEV_W-1:0]  tgt_dev,
  input logic [FN_W-1:0]   tgt_fn,
  input logic              io_req,
  input logic [1:0]        io_size,
  input logic              io_done,
  input logic [DATA_W-1:0] io_rdata,
  input logic              ds_req_valid,
  input logic              ds_req_ready,
  input logic              ds_wr,
  input logic [OFS_W-1:0]  ds_offset,
  input logic [1:0]        ds_size,
  input logic [DATA_W-1:0] ds_wdata,
  input logic [DATA_W-1:0] addr_q
);
  // R1: a completion only follows a held host request
  a_r1_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    io_done |-> $past(io_req));

  // R2: stored address never holds bits outside the keep mask
  a_r2_addr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q & ~ADDR_KEEP) == '0);

  // R4: no downstream request while the window is disabled
  a_r4_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req_valid |-> addr_q[EN_BIT]);

  // R7: only the programmed target is ever addressed
  a_r7_req_hits_target: assert property (@(posedge clk) disable iff (!rst_n)
    ds_req_valid |-> (addr_q[BUS_LSB+BUS_W-1:BUS_LSB] == tgt_bus) &&
                     (addr_q[DEV_LSB+DEV_W-1:DEV_LSB] == tgt_dev) &&
                     (addr_q[FN_LSB+FN_W-1:FN_LSB] == tgt_fn));

  // R6: dword requests are always lane aligned
  a_r6_dword_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req_valid && ds_size == SZ_DWORD) |-> ds_offset[1:0] == 2'b00);

  // R8: byte read data is zero-extended
  a_r8_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (io_done && io_size == SZ_BYTE) |-> (io_rdata >> 8) == '0);

  // R9: request holds stable until accepted
  a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req_valid && !ds_req_ready) |=>
      ds_req_valid && $stable(ds_wr) && $stable(ds_offset) &&
      $stable(ds_size) && $stable(ds_wdata));
endmodule

bind cfg_port_decoder cfgdec_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .tgt_bus      (tgt_bus),
  .tgt_dev      (tgt_dev),
  .tgt_fn       (tgt_fn),
  .io_req       (io_req),
  .io_size      (io_size),
  .io_done      (io_done),
  .io_rdata     (io_rdata),
  .ds_req_valid (ds_req_valid),
  .ds_req_ready (ds_req_ready),
  .ds_wr        (ds_wr),
  .ds_offset    (ds_offset),
  .ds_size      (ds_size),
  .ds_wdata     (ds_wdata),
  .addr_q       (addr_q)
);

// File: tb/cfg_port_decoder_tb.sv
`timescale 1ns/1ps
module cfg_port_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tgt_bus = 8'h12;
  logic [4:0]  tgt_dev = 5'h05;
  logic [2:0]  tgt_fn  = 3'h3;
  logic        io_req = 1'b0, io_wr = 1'b0;
  logic [15:0] io_port = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_done;
  logic [31:0] io_rdata;
  logic        ds_req_valid, ds_wr;
  logic        ds_req_ready = 1'b0;
  logic [7:0]  ds_offset;
  logic [1:0]  ds_size;
  logic [31:0] ds_wdata;
  logic        ds_rsp_valid = 1'b0;
  logic [31:0] ds_rsp_data = '0;

  int n_chk = 0, n_fail = 0;
  int stall = 0, rsp_dly = 0;
  logic [31:0] rsp_word = '0;

  // expected downstream requests: {wr, offset, size, wdata}
  logic [42:0] ds_q[$];
  string       ds_tag_q[$];
  logic [31:0] rd_q[$];
  string       rd_tag_q[$];

  always #2.5 clk = ~clk;

  cfg_port_decoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .tgt_bus(tgt_bus), .tgt_dev(tgt_dev), .tgt_fn(tgt_fn),
    .io_req(io_req), .io_wr(io_wr), .io_port(io_port), .io_size(io_size),
    .io_wdata(io_wdata), .io_done(io_done), .io_rdata(io_rdata),
    .ds_req_valid(ds_req_valid), .ds_req_ready(ds_req_ready),
    .ds_wr(ds_wr), .ds_offset(ds_offset), .ds_size(ds_size),
    .ds_wdata(ds_wdata), .ds_rsp_valid(ds_rsp_valid), .ds_rsp_data(ds_rsp_data)
  );

  // downstream model and request monitor
  initial begin
    forever begin
      @(negedge clk);
      if (ds_req_valid) begin
        logic [42:0] got, exp;
        logic        is_wr;
        repeat (stall) @(negedge clk);
        got   = {ds_wr, ds_offset, ds_size, ds_wdata};
        is_wr = ds_wr;
        n_chk++;
        if (ds_q.size() == 0) begin
          n_fail++;
          $display("FAIL R10 unexpected downstream request: actual %h expected none", got);
        end else begin
          string t;
          exp = ds_q.pop_front();
          t   = ds_tag_q.pop_front();
          if (!exp[42]) begin got[31:0] = '0; exp[31:0] = '0; end
          if (got !== exp) begin
            n_fail++;
            $display("FAIL %s request: actual %h expected %h", t, got, exp);
          end
        end
        ds_req_ready = 1'b1;
        @(negedge clk);
        ds_req_ready = 1'b0;
        if (!is_wr) begin
          repeat (rsp_dly) @(negedge clk);
          ds_rsp_data  = rsp_word;
          ds_rsp_valid = 1'b1;
          @(negedge clk);
          ds_rsp_valid = 1'b0;
          ds_rsp_data  = 32'hFFFF_FFFF;
        end
      end
    end
  end

  // host completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (io_done && !io_wr) begin
        logic [31:0] e;
        string t;
        n_chk++;
        if (rd_q.size() == 0) begin
          n_fail++;
          $display("FAIL R1 unexpected read completion: actual %h expected none", io_rdata);
        end else begin
          e = rd_q.pop_front();
          t = rd_tag_q.pop_front();
          if (io_rdata !== e) begin
            n_fail++;
            $display("FAIL %s read data: actual %h expected %h", t, io_rdata, e);
          end
        end
      end
    end
  end

  task automatic do_io(input logic wr, input logic [15:0] port, input logic [1:0] sz,
                       input logic [31:0] wd, input logic fwd, input logic [7:0] ofs,
                       input logic [31:0] rsp, input logic [31:0] exp_rd, input string tag);
    if (fwd) begin
      ds_q.push_back({wr, ofs, sz, wd});
      ds_tag_q.push_back(tag);
    end
    if (!wr) begin
      rd_q.push_back(exp_rd);
      rd_tag_q.push_back(tag);
    end
    rsp_word = rsp;
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_port = port; io_size = sz; io_wdata = wd;
    do @(negedge clk); while (!io_done);
    io_req = 1'b0;
    io_wdata = 32'h0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    do_io(0, 16'h0CF8, 2, 0, 0, 0, 0, 32'h0, "R1");

    // R4 window disabled
    do_io(0, 16'h0CFC, 0, 0, 0, 0, 0, 32'h0, "R4");
    do_io(1, 16'h0CFC, 2, 32'h1111_2222, 0, 0, 0, 0, "R4");
    do_io(0, 16'h0CFE, 1, 0, 0, 0, 0, 32'h0, "R4");

    // R2 mask and read back
    do_io(1, 16'h0CF8, 2, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2");
    do_io(0, 16'h0CF8, 2, 0, 0, 0, 0, 32'h80FF_FFFC, "R2");
    do_io(1, 16'h0CF8, 2, 32'h7F12_2B43, 0, 0, 0, 0, "R2");
    do_io(0, 16'h0CF8, 2, 0, 0, 0, 0, 32'h0012_2B40, "R2");
    do_io(1, 16'h0CF8, 2, 32'h8012_2B43, 0, 0, 0, 0, "R2");
    do_io(0, 16'h0CF8, 2, 0, 0, 0, 0, 32'h8012_2B40, "R2");

    // R3 narrow accesses to the address port
    do_io(1, 16'h0CF8, 0, 32'h0000_0000, 0, 0, 0, 0, "R3");
    do_io(1, 16'h0CF8, 1, 32'h0000_1234, 0, 0, 0, 0, "R3");
    do_io(0, 16'h0CF8, 0, 0, 0, 0, 0, 32'h0, "R3");
    do_io(0, 16'h0CF8, 1, 0, 0, 0, 0, 32'h0, "R3");
    do_io(0, 16'h0CF8, 2, 0, 0, 0, 0, 32'h8012_2B40, "R3");

    // R5 / R8 byte and word lanes, zero extension
    do_io(0, 16'h0CFE, 0, 0, 1, 8'h42, 32'hAABB_CCDD, 32'h0000_00DD, "R5_R8");
    stall = 2; rsp_dly = 3;
    do_io(0, 16'h0CFD, 1, 0, 1, 8'h41, 32'h1234_ABCD, 32'h0000_ABCD, "R5_R8");
    do_io(1, 16'h0CFF, 0, 32'h0000_005A, 1, 8'h43, 0, 0, "R5_R9");
    stall = 0; rsp_dly = 1;
    do_io(1, 16'h0CFC, 1, 32'h0000_BEEF, 1, 8'h40, 0, 0, "R5");
    do_io(0, 16'h0CFC, 0, 0, 1, 8'h40, 32'hFFFF_FF81, 32'h0000_0081, "R5_R8");

    // R6 dword accesses to the window
    stall = 3; rsp_dly = 4;
    do_io(0, 16'h0CFC, 2, 0, 1, 8'h40, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R6_R8");
    do_io(1, 16'h0CFC, 2, 32'hCAFE_F00D, 1, 8'h40, 0, 0, "R6_R9");
    stall = 0; rsp_dly = 0;
    do_io(0, 16'h0CFE, 2, 0, 0, 0, 0, 32'h0, "R6");
    do_io(1, 16'h0CFD, 2, 32'h5555_AAAA, 0, 0, 0, 0, "R6");

    // offset wrap at 0xFF
    do_io(1, 16'h0CF8, 2, 32'h8012_2BFC, 0, 0, 0, 0, "R5");
    do_io(0, 16'h0CFF, 0, 0, 1, 8'hFF, 32'h0000_0077, 32'h0000_0077, "R5");

    // R7 each field mismatching on its own
    do_io(1, 16'h0CF8, 2, 32'h8013_2B40, 0, 0, 0, 0, "R7");
    do_io(0, 16'h0CFC, 2, 0, 0, 0, 0, 32'h0, "R7");
    do_io(1, 16'h0CFC, 0, 32'h0000_0011, 0, 0, 0, 0, "R7");
    do_io(1, 16'h0CF8, 2, 32'h8012_3340, 0, 0, 0, 0, "R7");
    do_io(0, 16'h0CFC, 1, 0, 0, 0, 0, 32'h0, "R7");
    do_io(1, 16'h0CF8, 2, 32'h8012_2C40, 0, 0, 0, 0, "R7");
    do_io(0, 16'h0CFD, 0, 0, 0, 0, 0, 32'h0, "R7");

    // R10 other ports and reserved size, window enabled and matching
    do_io(1, 16'h0CF8, 2, 32'h8012_2B40, 0, 0, 0, 0, "R10");
    do_io(0, 16'h03C0, 0, 0, 0, 0, 0, 32'h0, "R10");
    do_io(1, 16'h0CFB, 0, 32'h0000_0099, 0, 0, 0, 0, "R10");
    do_io(0, 16'h0D00, 1, 0, 0, 0, 0, 32'h0, "R10");
    do_io(0, 16'h0CFC, 3, 0, 0, 0, 0, 32'h0, "R10");
    do_io(1, 16'h0CFC, 3, 32'h0000_0001, 0, 0, 0, 0, "R10");
    do_io(0, 16'h0CF8, 2, 0, 0, 0, 0, 32'h8012_2B40, "R10");

    repeat (10) @(negedge clk);
    n_chk++;
    if (ds_q.size() != 0 || rd_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 scoreboard leftovers: actual %0d/%0d expected 0/0",
               ds_q.size(), rd_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule